// File: doc/BRIEF.md
# Peripheral Interrupt Latch and Wake Controller

This block sits between a set of peripherals and an 8-bit CPU core. Each peripheral raises a one-cycle event on its flag input, and the event is held in a per-source latch until software clears it. Software sees the latches through a status register and sets per-source enables through a control register. Both sit on a small register bus with read and write strobes. A request goes to the CPU only when its source is enabled and the global interrupt mask is clear. When more than one enabled source is pending, the lowest-numbered one wins, and its index is presented with the request.

A latch can be cleared in two ways. Software can write zero to its status bit. Or software can read status while the flag is set and then access that source's data register. Either clear drops the request even if it was never delivered. The global mask comes out of reset set. An acknowledge from the CPU sets the mask, a return-from-interrupt clears it, and software can also write it directly.

Two wake outputs serve the power controller. Any latched flag wakes the core from wait, whatever its enable or the mask. Only the sources chosen by a parameter mask can end halt. By default these are sources 0 (external pin) and 1 (end of bus suspend).

Top module: `irq_wake_ctrl`

## Requirements
- R1: After reset all flags and enables read 0, the global mask reads 1, and no request or wake output is asserted.
- R2: A one-cycle pulse on flag_in[i] sets status bit i from the next cycle on, and the bit stays set until it is cleared.
- R3: irq_req is 1 only while the mask is 0 and some source has both its flag and its enable bit set. A masked or disabled flag stays latched in status.
- R4: A write to the status register (address 0) clears each flag whose written bit is 0 and leaves flags whose written bit is 1 unchanged. The control register is at address 1 and is written and read back as a plain value.
- R5: A status read that sees flag i set arms source i. A later read or write of data address 2+i then clears flag i. A data access without a prior arming read does not clear the flag. Clearing the flag drops the arm.
- R6: A flag cleared while its enable is 0 does not produce a request when the enable is set later.
- R7: A flag input asserted in the same cycle as a clear of that flag leaves the flag set.
- R8: With several enabled flags pending, irq_idx gives the lowest pending enabled source index.
- R9: wake_wait is 1 whenever any flag is latched, regardless of enables and mask.
- R10: wake_halt is 1 only when a flag from a halt-capable source is latched (default: sources 0 and 1). Other sources never assert it.
- R11: cpu_ack sets the mask from the next cycle on, cpu_ret clears it, and mask_wr loads mask_val. cpu_ack has priority over cpu_ret, which has priority over mask_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | AW (4) | Register address: 0 status, 1 control, 2+i data of source i |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | NSRC (8) | Write data |
| bus_rdata | output | NSRC (8) | Read data (status, control, or 0 for data addresses) |
| flag_in | input | NSRC (8) | Per-source event pulses |
| mask_wr | input | 1 | Direct write of the global mask |
| mask_val | input | 1 | Value for mask_wr |
| cpu_ack | input | 1 | CPU accepted an interrupt; sets the mask |
| cpu_ret | input | 1 | Return from interrupt; clears the mask |
| irq_mask | output | 1 | Current global mask |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | IW (3) | Index of the winning source |
| wake_wait | output | 1 | Wake from wait mode |
| wake_halt | output | 1 | Wake from halt mode |

## Verification
A latch that wrongly holds or drops its value shows up on the status read and on wake_wait in the cycle after the event. A stray or missing arm shows up as a data access that clears the wrong flag, or fails to clear, and the next status read reveals it. A wrong mask state shows up on irq_req one cycle after the acknowledge or return. A faulty priority shows up on irq_idx as soon as two enabled flags are pending together.

// File: rtl/irq_wake_pkg.sv
// Shared register map constants for the interrupt latch and wake controller.
// Assumes a flat address space where data register of source i sits at DATA_BASE+i.
package irq_wake_pkg;
    localparam int STATUS_ADDR = 0;
    localparam int CTRL_ADDR   = 1;
    localparam int DATA_BASE   = 2;
endpackage

// File: rtl/irq_bus_decode.sv
// Decodes the register bus into status/control selects and per-source
// data-register access hits. Assumes at most one of rd/wr is meaningful per cycle.
module irq_bus_decode #(
    parameter int NSRC = 8,
    parameter int AW   = 4
) (
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    output logic            st_rd,
    output logic            st_wr,
    output logic            ct_wr,
    output logic            ct_sel,
    output logic [NSRC-1:0] data_hit
);
    import irq_wake_pkg::*;

    // Register selects for status and control.
    always_comb begin
        st_rd  = bus_rd && (int'(bus_addr) == STATUS_ADDR);
        st_wr  = bus_wr && (int'(bus_addr) == STATUS_ADDR);
        ct_wr  = bus_wr && (int'(bus_addr) == CTRL_ADDR);
        ct_sel = (int'(bus_addr) == CTRL_ADDR);
    end

    // One hit line per source data register, read or write.
    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign data_hit[i] = (bus_rd || bus_wr) && (int'(bus_addr) == DATA_BASE + i);
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Holds the per-source flag latches, the two-step clear arms and the
// enable register. A set from flag_in overrides any clear in the same cycle.
module irq_flag_bank #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flag_in,
    input  logic            st_rd,
    input  logic            st_wr,
    input  logic            ct_wr,
    input  logic [NSRC-1:0] wdata,
    input  logic [NSRC-1:0] data_hit,
    output logic [NSRC-1:0] flags,
    output logic [NSRC-1:0] enables
);
    logic [NSRC-1:0] arm;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] flags_nxt;
    logic [NSRC-1:0] arm_nxt;

    // Combine write-zero clears and armed data-access clears.
    always_comb begin
        clr_vec   = (st_wr ? ~wdata : '0) | (arm & data_hit);
        flags_nxt = (flags & ~clr_vec) | flag_in;
        arm_nxt   = st_rd ? flags : (arm & flags & ~clr_vec);
    end

    // State update for latches, arms and enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags   <= '0;
            arm     <= '0;
            enables <= '0;
        end else begin
            flags <= flags_nxt;
            arm   <= arm_nxt;
            if (ct_wr) begin
                enables <= wdata;
            end
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority selector: lowest pending enabled index wins.
// Assumes NSRC >= 2 so the index has at least one bit.
module irq_prio_pick #(
    parameter int NSRC = 8,
    localparam int IW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [IW-1:0]   idx
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IW'(i);
            end
        end
        any = |pend;
    end
endmodule

// File: rtl/irq_mask_reg.sv
// Global interrupt mask. Resets set; acknowledge sets, return clears,
// direct write loads a value. Priority: ack, then return, then write.
module irq_mask_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_ack,
    input  logic cpu_ret,
    input  logic mask_wr,
    input  logic mask_val,
    output logic mask
);
    // Prioritised mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= 1'b1;
        end else if (cpu_ack) begin
            mask <= 1'b1;
        end else if (cpu_ret) begin
            mask <= 1'b0;
        end else if (mask_wr) begin
            mask <= mask_val;
        end
    end
endmodule

// File: rtl/irq_wake_ctrl.sv
// Top: peripheral interrupt latches, gated CPU request with priority index,
// and wait/halt wake outputs. HALT_SRC selects sources allowed to end halt.
module irq_wake_ctrl #(
    parameter int          NSRC     = 8,
    parameter int          AW       = 4,
    parameter logic [NSRC-1:0] HALT_SRC = 8'b0000_0011,
    localparam int         IW       = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic            bus_rd,
    input  logic            bus_wr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    input  logic [NSRC-1:0] flag_in,
    input  logic            mask_wr,
    input  logic            mask_val,
    input  logic            cpu_ack,
    input  logic            cpu_ret,
    output logic            irq_mask,
    output logic            irq_req,
    output logic [IW-1:0]   irq_idx,
    output logic            wake_wait,
    output logic            wake_halt
);
    logic            st_rd, st_wr, ct_wr, ct_sel;
    logic [NSRC-1:0] data_hit;
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] ctrl_q;
    logic            pend_any;

    irq_bus_decode #(.NSRC(NSRC), .AW(AW)) u_dec (
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .st_rd    (st_rd),
        .st_wr    (st_wr),
        .ct_wr    (ct_wr),
        .ct_sel   (ct_sel),
        .data_hit (data_hit)
    );

    irq_flag_bank #(.NSRC(NSRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_in  (flag_in),
        .st_rd    (st_rd),
        .st_wr    (st_wr),
        .ct_wr    (ct_wr),
        .wdata    (bus_wdata),
        .data_hit (data_hit),
        .flags    (flags_q),
        .enables  (ctrl_q)
    );

    irq_prio_pick #(.NSRC(NSRC)) u_pick (
        .pend (flags_q & ctrl_q),
        .any  (pend_any),
        .idx  (irq_idx)
    );

    irq_mask_reg u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_ack  (cpu_ack),
        .cpu_ret  (cpu_ret),
        .mask_wr  (mask_wr),
        .mask_val (mask_val),
        .mask     (irq_mask)
    );

    // Read mux: status, control, or zero for data addresses.
    always_comb begin
        if (int'(bus_addr) == irq_wake_pkg::STATUS_ADDR) begin
            bus_rdata = flags_q;
        end else if (ct_sel) begin
            bus_rdata = ctrl_q;
        end else begin
            bus_rdata = '0;
        end
    end

    // Request gating and wake outputs.
    always_comb begin
        irq_req   = pend_any && !irq_mask;
        wake_wait = |flags_q;
        wake_halt = |(flags_q & HALT_SRC);
    end
endmodule

// File: rtl/irq_wake_ctrl_chk.sv
// Property checker for irq_wake_ctrl, attached by bind below.
module irq_wake_ctrl_chk #(
    parameter int NSRC = 8,
    localparam int IW = $clog2(NSRC)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [NSRC-1:0] flag_in,
    input logic            cpu_ack,
    input logic            cpu_ret,
    input logic            irq_mask,
    input logic            irq_req,
    input logic [IW-1:0]   irq_idx,
    input logic            wake_wait,
    input logic            wake_halt,
    input logic [NSRC-1:0] flags_q,
    input logic [NSRC-1:0] ctrl_q
);
    // R2: with no bus activity no latched flag is lost.
    p_flag_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !bus_rd) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R3: a request never leaves while masked.
    p_req_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !irq_mask);

    // R7: an asserted flag input is always latched next cycle.
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_in != '0) |=> ((flags_q & $past(flag_in)) == $past(flag_in)));

    // R8: the reported index is a pending enabled source.
    p_idx_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (flags_q[irq_idx] && ctrl_q[irq_idx]));

    // R10: halt wake implies wait wake.
    p_halt_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_halt |-> wake_wait);

    // R11: acknowledge sets the mask.
    p_ack_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> irq_mask);

    // R11: return clears the mask when no acknowledge competes.
    p_ret_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ret && !cpu_ack) |=> !irq_mask);
endmodule

bind irq_wake_ctrl irq_wake_ctrl_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .flag_in   (flag_in),
    .cpu_ack   (cpu_ack),
    .cpu_ret   (cpu_ret),
    .irq_mask  (irq_mask),
    .irq_req   (irq_req),
    .irq_idx   (irq_idx),
    .wake_wait (wake_wait),
    .wake_halt (wake_halt),
    .flags_q   (flags_q),
    .ctrl_q    (ctrl_q)
);

// File: tb/irq_wake_ctrl_test.sv
// Self-checking bench: vector table for gating/priority, then directed tests.
module irq_wake_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // {raise[7:0], enable[7:0], exp_req, 4'b0, exp_idx[2:0]}
    localparam logic [23:0] VEC [NV] = '{
        {8'h01, 8'hFF, 1'b1, 4'd0, 3'd0},
        {8'h0C, 8'hFF, 1'b1, 4'd0, 3'd2},
        {8'h0C, 8'h08, 1'b1, 4'd0, 3'd3},
        {8'hF0, 8'h0F, 1'b0, 4'd0, 3'd0},
        {8'h81, 8'h80, 1'b1, 4'd0, 3'd7},
        {8'hFF, 8'h00, 1'b0, 4'd0, 3'd0},
        {8'hA0, 8'hE0, 1'b1, 4'd0, 3'd5}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] flag_in = '0;
    logic       mask_wr = 1'b0, mask_val = 1'b0, cpu_ack = 1'b0, cpu_ret = 1'b0;
    logic       irq_mask, irq_req, wake_wait, wake_halt;
    logic [2:0] irq_idx;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] rv;

    irq_wake_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .flag_in(flag_in), .mask_wr(mask_wr), .mask_val(mask_val),
        .cpu_ack(cpu_ack), .cpu_ret(cpu_ret), .irq_mask(irq_mask),
        .irq_req(irq_req), .irq_idx(irq_idx), .wake_wait(wake_wait),
        .wake_halt(wake_halt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic raise(input logic [7:0] f);
        flag_in = f;
        tick();
        flag_in = '0;
    endtask

    task automatic set_mask(input logic v);
        mask_wr = 1'b1; mask_val = v;
        tick();
        mask_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 mask", irq_mask, 1);
        check("R1 req", irq_req, 0);
        check("R1 wake", {wake_wait, wake_halt}, 0);
        rd(4'd0, rv); check("R1 status", rv, 0);
        rd(4'd1, rv); check("R1 ctrl", rv, 0);

        set_mask(1'b0);
        // R8 R2 R9 vector table
        for (int v = 0; v < NV; v++) begin
            wr(4'd0, 8'h00);
            wr(4'd1, VEC[v][15:8]);
            raise(VEC[v][23:16]);
            check("R8 req", irq_req, VEC[v][7]);
            if (VEC[v][7]) check("R8 idx", irq_idx, VEC[v][2:0]);
            check("R9 wake_wait", wake_wait, 1);
            rd(4'd0, rv); check("R2 status", rv, VEC[v][23:16]);
        end

        // R3 masked request stays pending
        wr(4'd0, 8'h00);
        wr(4'd1, 8'hFF);
        rd(4'd1, rv); check("R4 ctrl readback", rv, 8'hFF);
        set_mask(1'b1);
        raise(8'h10);
        check("R3 masked req", irq_req, 0);
        rd(4'd0, rv); check("R3 pending", rv, 8'h10);
        set_mask(1'b0);
        check("R3 unmasked req", irq_req, 1);
        check("R3 idx", irq_idx, 4);

        // R11 ack/return
        cpu_ack = 1'b1; tick(); cpu_ack = 1'b0;
        check("R11 ack mask", irq_mask, 1);
        check("R11 ack req", irq_req, 0);
        cpu_ret = 1'b1; tick(); cpu_ret = 1'b0;
        check("R11 ret mask", irq_mask, 0);
        check("R11 ret req", irq_req, 1);
        cpu_ack = 1'b1; cpu_ret = 1'b1; tick(); cpu_ack = 1'b0; cpu_ret = 1'b0;
        check("R11 ack priority", irq_mask, 1);
        set_mask(1'b0);

        // R4 write-zero clears, write-one keeps
        wr(4'd0, 8'hEF);
        check("R4 cleared req", irq_req, 0);
        raise(8'h06);
        wr(4'd0, 8'hFD);
        rd(4'd0, rv); check("R4 partial clear", rv, 8'h04);

        // R6 cleared while disabled is lost
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h00);
        raise(8'h20);
        wr(4'd0, 8'h00);
        wr(4'd1, 8'h20);
        check("R6 lost request", irq_req, 0);

        // R5 two-step clear
        wr(4'd0, 8'h00);
        raise(8'h08);
        wr(4'd5, 8'h00);
        rd(4'd0, rv); check("R5 no arm no clear", rv, 8'h08);
        rd(4'd5, rv);
        rd(4'd0, rv); check("R5 armed clear", rv, 8'h00);
        raise(8'h0C);
        rd(4'd0, rv);
        wr(4'd4, 8'h00);
        rd(4'd0, rv); check("R5 only own source", rv, 8'h08);
        wr(4'd0, 8'h00);
        raise(8'h40);
        rd(4'd0, rv);
        wr(4'd0, 8'hBF);
        raise(8'h40);
        rd(4'd8, rv);
        check("R5 arm dropped", bus_rdata, 8'h00);
        rd(4'd0, rv); check("R5 arm dropped status", rv, 8'h40);

        // R7 set wins over clear
        wr(4'd0, 8'h00);
        flag_in = 8'h02;
        wr(4'd0, 8'h00);
        flag_in = 8'h00;
        rd(4'd0, rv); check("R7 set wins", rv, 8'h02);

        // R10 halt wake sources
        wr(4'd0, 8'h00);
        check("R9 idle wake_wait", wake_wait, 0);
        raise(8'h20);
        check("R10 non-halt source", wake_halt, 0);
        check("R9 any source", wake_wait, 1);
        raise(8'h02);
        check("R10 suspend-end source", wake_halt, 1);
        wr(4'd0, 8'h00);
        raise(8'h01);
        check("R10 pin source", wake_halt, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule